// File: doc/BRIEF.md
# Zero-turnaround pipelined synchronous SRAM

This block is a synthesizable model of a synchronous static RAM that accepts a new read or write command on every enabled clock edge. A read and a write can follow each other in any order with no idle cycle, because both kinds of command use the data bus in the same slot. That slot is the clock period after the second enabled edge following the command. Read data comes out of an edge-triggered output register. Write data is captured at the end of the slot, which is the third enabled edge after the command. The write address and byte enables are delayed through a register pipeline so that they line up with that data.

The array is built from registers, and its size is set by parameters. Per-lane write enables select which 9-bit lanes a write updates. A read whose address matches a write that is still in flight returns the pending bytes merged with the array word.

The advance input walks a 4-beat burst from the last loaded address, in either linear or interleaved order. Deasserting clock enable suspends the whole pipeline. The sleep input suspends it as well and also turns the data bus off asynchronously. The output enable acts on the bus drivers without waiting for a clock edge. The bidirectional data bus is split into `data_i`, `data_o` and `data_oe_o`.

Top module: `zt_sram`

## Requirements
- R1: On a load edge (`adv_i`=0) the device is selected only when `cs_a_ni`=0, `cs_b_i`=1 and `cs_c_ni`=0. A load edge with any other combination issues no command: it writes nothing and never drives the bus.
- R2: A read command taken at enabled edge k gives `data_oe_o`=1 and the addressed word on `data_o` after enabled edge k+2. Both hold until the next enabled edge, and `oe_i`=1 is needed for the bus to drive.
- R3: A write command taken at enabled edge k stores the `data_i` value sampled at enabled edge k+3 into the addressed word.
- R4: Lane l is bits [9l+8:9l]. A write updates lane l only when `byte_we_i[l]`=1 at the command edge. The other lanes keep their contents.
- R5: Commands may alternate between read and write on every enabled edge with no idle cycle. A read issued one enabled edge after a write to the same address returns the written lanes merged with the stored lanes.
- R6: An advance edge (`adv_i`=1) repeats the previous command type and ignores the chip selects and `wr_i`. Its address is the loaded base with the low two bits replaced for beat n (n = 1, 2, 3…). With `lin_burst_i`=1 the replacement is (base+n) mod 4; with `lin_burst_i`=0 it is base XOR n.
- R7: An advance edge that follows a deselected load issues no command.
- R8: While `clk_en_i`=0 every edge is ignored. Commands in flight are held, `data_o` and `data_oe_o` are stable, and processing resumes on the next enabled edge.
- R9: `oe_i`=0 forces `data_oe_o`=0 at once, with no clock edge needed, and does not disturb the pipeline.
- R10: `sleep_i`=1 forces `data_oe_o`=0 at once and makes every edge ignored, in the same way as R8.
- R11: While `rst_ni`=0 and after its release, no command is in flight and `data_oe_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_i | input | 1 | Clock enable, 0 suspends |
| cs_a_ni | input | 1 | Chip select, active low |
| cs_b_i | input | 1 | Chip select, active high |
| cs_c_ni | input | 1 | Chip select, active low |
| addr_i | input | ADDR_W | Word address |
| adv_i | input | 1 | 1 advances the burst, 0 loads a new command |
| wr_i | input | 1 | 1 write, 0 read |
| byte_we_i | input | LANES | Per-lane write enables |
| oe_i | input | 1 | Asynchronous output enable |
| sleep_i | input | 1 | Asynchronous power-down |
| lin_burst_i | input | 1 | 1 linear, 0 interleaved burst order |
| data_i | input | LANES*9 | Write data from the bus |
| data_o | output | LANES*9 | Read data to the bus |
| data_oe_o | output | 1 | Bus driver enable |

## Verification
The bench first fills every word, then reads each one back, so any storage or latency error shows up as a wrong word. Alternating write/read runs that target the same address tell correct forwarding apart from returning stale data. Partial lane masks separate lane decoding from whole-word writes. Linear and interleaved bursts, and advances that carry conflicting selects and `wr_i`, check the address sequence and the command repeat. Finally, reads are interrupted by suspend, sleep and output-enable pulses in the middle of the pipeline, which shows that these conditions hold state rather than drop it.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;
  localparam int CMD_W = 2;
  typedef enum logic [CMD_W-1:0] {
    CMD_IDLE = 2'd0,
    CMD_RD   = 2'd1,
    CMD_WR   = 2'd2
  } cmd_e;
endpackage

// File: rtl/zt_sram_ctrl.sv
module zt_sram_ctrl
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int LANES   = 4,
  parameter int BURST_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              cs_a_ni,
  input  logic              cs_b_i,
  input  logic              cs_c_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              adv_i,
  input  logic              wr_i,
  input  logic [LANES-1:0]  byte_we_i,
  input  logic              lin_burst_i,
  output cmd_e              cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LANES-1:0]  be_o
);
  cmd_e                cmd_q, cmd_d;
  logic [ADDR_W-1:0]   addr_q, addr_d, base_q, base_d;
  logic [LANES-1:0]    be_q;
  logic [BURST_W-1:0]  cnt_q, cnt_d, cnt_n, lo_n;
  logic                sel;

  always_comb begin
    sel   = ~cs_a_ni & cs_b_i & ~cs_c_ni;
    cnt_n = cnt_q + 1'b1;
    lo_n  = lin_burst_i ? base_q[BURST_W-1:0] + cnt_n
                        : base_q[BURST_W-1:0] ^ cnt_n;
    if (adv_i) begin
      cmd_d  = cmd_q;
      base_d = base_q;
      cnt_d  = cnt_n;
      addr_d = {base_q[ADDR_W-1:BURST_W], lo_n};
    end else begin
      cmd_d  = !sel ? CMD_IDLE : (wr_i ? CMD_WR : CMD_RD);
      base_d = addr_i;
      cnt_d  = '0;
      addr_d = addr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= CMD_IDLE;
      addr_q <= '0;
      base_q <= '0;
      cnt_q  <= '0;
      be_q   <= '0;
    end else if (en_i) begin
      cmd_q  <= cmd_d;
      addr_q <= addr_d;
      base_q <= base_d;
      cnt_q  <= cnt_d;
      be_q   <= byte_we_i;
    end
  end

  assign cmd_o  = cmd_q;
  assign addr_o = addr_q;
  assign be_o   = be_q;
endmodule

// File: rtl/zt_sram_stage.sv
module zt_sram_stage #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/zt_sram_array.sv
module zt_sram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    rd_i,
  input  logic [ADDR_W-1:0]       raddr_i,
  input  logic                    wr_i,
  input  logic [ADDR_W-1:0]       waddr_i,
  input  logic [LANES-1:0]        wbe_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] dout_o,
  output logic                    valid_o
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 2 ** ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] merged;
  logic              hit;

  always_ff @(posedge clk_i) begin
    if (en_i && wr_i) begin
      for (int l = 0; l < LANES; l++) begin
        if (wbe_i[l]) mem[waddr_i][l*LANE_W +: LANE_W] <= wdata_i[l*LANE_W +: LANE_W];
      end
    end
  end

  // a write committing on this edge is bypassed into the read
  always_comb begin
    hit    = wr_i && (waddr_i == raddr_i);
    merged = mem[raddr_i];
    for (int l = 0; l < LANES; l++) begin
      if (hit && wbe_i[l]) merged[l*LANE_W +: LANE_W] = wdata_i[l*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_o  <= '0;
      valid_o <= 1'b0;
    end else if (en_i) begin
      valid_o <= rd_i;
      if (rd_i) dout_o <= merged;
    end
  end
endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int LANES   = 4,
  parameter int LANE_W  = 9,
  parameter int BURST_W = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clk_en_i,
  input  logic                    cs_a_ni,
  input  logic                    cs_b_i,
  input  logic                    cs_c_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    adv_i,
  input  logic                    wr_i,
  input  logic [LANES-1:0]        byte_we_i,
  input  logic                    oe_i,
  input  logic                    sleep_i,
  input  logic                    lin_burst_i,
  input  logic [LANES*LANE_W-1:0] data_i,
  output logic [LANES*LANE_W-1:0] data_o,
  output logic                    data_oe_o
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int REQ_W  = CMD_W + ADDR_W + LANES;
  localparam int NSTG   = 3;

  logic                    en;
  cmd_e                    cmd0, cmd_rd, cmd_wr;
  logic [ADDR_W-1:0]       addr0;
  logic [LANES-1:0]        be0;
  logic [NSTG-1:0][REQ_W-1:0] req;
  logic [DATA_W-1:0]       dout;
  logic                    rd_valid;

  assign en = clk_en_i & ~sleep_i;

  zt_sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES), .BURST_W(BURST_W)) u_ctrl (
    .clk_i, .rst_ni, .en_i(en), .cs_a_ni, .cs_b_i, .cs_c_ni, .addr_i, .adv_i,
    .wr_i, .byte_we_i, .lin_burst_i, .cmd_o(cmd0), .addr_o(addr0), .be_o(be0)
  );

  assign req[0] = {cmd0, addr0, be0};

  for (genvar s = 1; s < NSTG; s++) begin : g_stage
    zt_sram_stage #(.W(REQ_W)) u_stage (
      .clk_i, .rst_ni, .en_i(en), .d_i(req[s-1]), .q_o(req[s])
    );
  end

  assign cmd_rd = cmd_e'(req[1][REQ_W-1 -: CMD_W]);
  assign cmd_wr = cmd_e'(req[2][REQ_W-1 -: CMD_W]);

  zt_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk_i, .rst_ni, .en_i(en),
    .rd_i(cmd_rd == CMD_RD), .raddr_i(req[1][LANES +: ADDR_W]),
    .wr_i(cmd_wr == CMD_WR), .waddr_i(req[2][LANES +: ADDR_W]),
    .wbe_i(req[2][LANES-1:0]), .wdata_i(data_i),
    .dout_o(dout), .valid_o(rd_valid)
  );

  assign data_o    = dout;
  assign data_oe_o = rd_valid & oe_i & ~sleep_i;
endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clk_en_i,
  input logic              sleep_i,
  input logic              oe_i,
  input logic [DATA_W-1:0] data_o,
  input logic              data_oe_o
);
  AST_SUSPEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_i |=> $stable(data_o)); // R8
  AST_SLEEP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> $stable(data_o)); // R10
  AST_SLEEP_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> !data_oe_o); // R10
  AST_OE_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> !data_oe_o); // R9
  AST_RESET_IDLE: assert property (@(posedge clk_i)
    !rst_ni |=> !data_oe_o); // R11
endmodule

bind zt_sram zt_sram_chk #(.DATA_W(LANES*LANE_W)) u_chk (
  .clk_i, .rst_ni, .clk_en_i, .sleep_i, .oe_i, .data_o, .data_oe_o
);

// File: tb/tb_zt_sram.sv
`timescale 1ns/1ps
module tb_zt_sram;
  localparam int AW = 6;
  localparam int LN = 4;
  localparam int DW = 36;

  logic clk_i = 0, rst_ni = 0, clk_en_i = 1, cs_a_ni = 1, cs_b_i = 0, cs_c_ni = 1;
  logic [AW-1:0] addr_i = '0;
  logic adv_i = 0, wr_i = 0, oe_i = 1, sleep_i = 0, lin_burst_i = 1;
  logic [LN-1:0] byte_we_i = '0;
  logic [DW-1:0] data_i = '0, data_o;
  logic data_oe_o;

  zt_sram dut (.*);

  always #5 clk_i = ~clk_i;

  typedef struct { int kind; int addr; logic [LN-1:0] be; logic [DW-1:0] data; int age; } ent_t;
  ent_t q[$];
  logic [DW-1:0] mm [64];
  int m_last, m_base, m_cnt, seed;
  logic m_valid;
  logic [DW-1:0] m_dout;
  int errors = 0, checks = 0;
  bit done = 0;

  function automatic logic [DW-1:0] gen(int s);
    return DW'(s * 36'h9E3779B1) ^ DW'(36'hA5C3_1E27 + s);
  endfunction

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare(string tag);
    logic eoe;
    eoe = m_valid && oe_i && !sleep_i;
    chk(tag, DW'(data_oe_o), DW'(eoe));
    if (eoe) chk(tag, data_o, m_dout);
  endtask

  task automatic model_edge(bit sel, int a, bit adv, bit wr, logic [LN-1:0] be);
    int kind, ad, lo;
    if (!(clk_en_i && !sleep_i)) return;
    foreach (q[i]) if (q[i].kind == 2 && q[i].age == 2)
      for (int l = 0; l < LN; l++) if (q[i].be[l]) mm[q[i].addr][l*9 +: 9] = data_i[l*9 +: 9];
    m_valid = 0;
    foreach (q[i]) if (q[i].kind == 1 && q[i].age == 1) begin
      m_valid = 1; m_dout = mm[q[i].addr];
    end
    foreach (q[i]) q[i].age++;
    for (int i = q.size() - 1; i >= 0; i--)
      if ((q[i].kind == 1 && q[i].age >= 2) || q[i].age >= 3) q.delete(i);
    if (adv) begin
      kind = m_last; m_cnt++;
      lo = lin_burst_i ? ((m_base % 4) + m_cnt) % 4 : ((m_base % 4) ^ (m_cnt % 4));
      ad = (m_base / 4) * 4 + lo;
    end else begin
      kind = sel ? (wr ? 2 : 1) : 0; m_base = a; m_cnt = 0; ad = a;
    end
    m_last = kind;
    if (kind != 0) begin
      seed++;
      q.push_back('{kind: kind, addr: ad, be: be, data: gen(seed), age: 0});
    end
  endtask

  // cs = {cs_a_ni, cs_b_i, cs_c_ni}
  task automatic step(logic [2:0] cs, int a, bit adv, bit wr, logic [LN-1:0] be, string tag);
    bit sel;
    {cs_a_ni, cs_b_i, cs_c_ni} = cs;
    addr_i = AW'(a); adv_i = adv; wr_i = wr; byte_we_i = be;
    data_i = 36'h5_A5A5_A5A5;
    foreach (q[i]) if (q[i].kind == 2 && q[i].age == 2) data_i = q[i].data;
    sel = (cs == 3'b010);
    #1 compare(tag);
    @(posedge clk_i);
    model_edge(sel, a, adv, wr, be);
    @(negedge clk_i);
  endtask

  task automatic wr_c(int a, logic [LN-1:0] be, string tag); step(3'b010, a, 0, 1, be, tag); endtask
  task automatic rd_c(int a, string tag); step(3'b010, a, 0, 0, '0, tag); endtask
  task automatic nop(string tag); step(3'b110, 0, 0, 0, '0, tag); endtask
  task automatic flush(string tag); for (int i = 0; i < 4; i++) nop(tag); endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mm[i] = '0;
    m_last = 0; m_base = 0; m_cnt = 0; seed = 0; m_valid = 0; m_dout = '0;
    repeat (3) @(negedge clk_i);
    chk("R11 reset", DW'(data_oe_o), '0);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R11 after release", DW'(data_oe_o), '0);

    for (int i = 0; i < 64; i++) wr_c(i, 4'hF, "R3");
    flush("R3");
    for (int i = 0; i < 64; i++) rd_c(i, "R2");
    flush("R2");

    for (int i = 0; i < 8; i++) begin
      wr_c(8 + i, 4'hF, "R5"); rd_c(8 + i, "R5");
    end
    for (int i = 0; i < 6; i++) begin
      rd_c(20 + i, "R5"); wr_c(20 + i, 4'hF, "R5");
    end
    flush("R5");
    for (int i = 0; i < 6; i++) rd_c(20 + i, "R5");
    flush("R5");

    wr_c(30, 4'b0101, "R4"); flush("R4");
    rd_c(30, "R4");
    wr_c(31, 4'b1000, "R4"); rd_c(31, "R4");
    wr_c(31, 4'b0010, "R4"); flush("R4");
    rd_c(31, "R4"); flush("R4");

    step(3'b110, 40, 0, 1, 4'hF, "R1");
    step(3'b000, 41, 0, 1, 4'hF, "R1");
    step(3'b011, 42, 0, 1, 4'hF, "R1");
    step(3'b100, 43, 0, 0, 4'hF, "R1");
    flush("R1");
    for (int i = 40; i < 44; i++) rd_c(i, "R1");
    flush("R1");

    lin_burst_i = 1;
    wr_c(18, 4'hF, "R6");
    step(3'b101, 0, 1, 0, 4'hF, "R6");
    step(3'b111, 0, 1, 0, 4'hF, "R6");
    step(3'b000, 0, 1, 0, 4'h3, "R6");
    flush("R6");
    for (int i = 16; i < 20; i++) rd_c(i, "R6");
    lin_burst_i = 0;
    rd_c(45, "R6");
    for (int i = 0; i < 3; i++) step(3'b101, 0, 1, 1, 4'hF, "R6");
    flush("R6");
    lin_burst_i = 1;

    nop("R7");
    step(3'b101, 0, 1, 1, 4'hF, "R7");
    step(3'b010, 0, 1, 1, 4'hF, "R7");
    flush("R7");
    for (int i = 0; i < 4; i++) rd_c(i, "R7");
    flush("R7");

    rd_c(50, "R8"); rd_c(51, "R8");
    clk_en_i = 0;
    for (int i = 0; i < 3; i++) step(3'b010, 60, 0, 1, 4'hF, "R8");
    clk_en_i = 1;
    wr_c(52, 4'hF, "R8");
    clk_en_i = 0;
    for (int i = 0; i < 2; i++) step(3'b010, 61, 0, 0, 4'hF, "R8");
    clk_en_i = 1;
    flush("R8");
    rd_c(52, "R8"); flush("R8");

    rd_c(5, "R9"); rd_c(6, "R9"); nop("R9");
    oe_i = 0; nop("R9");
    oe_i = 1; nop("R9"); flush("R9");

    rd_c(7, "R10"); rd_c(9, "R10");
    sleep_i = 1;
    for (int i = 0; i < 3; i++) step(3'b010, 62, 0, 1, 4'hF, "R10");
    sleep_i = 0;
    flush("R10");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule